// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block chooses which interrupt request a small 8-bit microcontroller core services next. It reads the core's enable, priority, timer-control, serial-control and timer-2 control registers, along with the current 16-bit program counter and the 8-bit stack pointer. On every machine cycle that the core marks with `cycle_en`, it polls four sources: timer 0, timer 1, serial and timer 2. Polling is done in two priority classes. The class currently in service gates which classes are looked at.

When a request is accepted, the block saves the return address on the internal stack. It does this with two byte writes on consecutive cycles, low byte first. In the second cycle it also writes back the new stack pointer, writes the vector into the program counter and pulses a flag-clear strobe for a timer source. A return-from-interrupt strobe drops the in-service class back to the class that was interrupted, or to idle.

Top module: `irq_arbiter`

## Requirements
- R1: No request is accepted while bit 7 of `ie_reg` (global enable) is 0.
- R2: A source is taken only when its own enable bit is 1 in `ie_reg`. The enable bits are bit 1 for timer 0, bit 3 for timer 1, bit 4 for serial and bit 5 for timer 2.
- R3: `ip_reg` uses the same bit positions as `ie_reg`. A 1 puts the source in the high class and a 0 puts it in the low class. A pending high-class source wins over any low-class source, whatever their polling order.
- R4: Within one class, sources are polled in the order timer 0, timer 1, serial, timer 2. Only the first pending one is taken.
- R5: The request bits and their vectors are:
  - `tcon_reg[5]` is timer 0 and goes to 0x000B.
  - `tcon_reg[7]` is timer 1 and goes to 0x001B.
  - `scon_reg[0] | scon_reg[1]` is serial and goes to 0x0023.
  - `t2con_reg[7]` is timer 2 and goes to 0x002B.
- R6: In the cycle after acceptance, `stk_we` is 1 with address sp+1 and data pc[7:0]. In the next cycle, `stk_we` is 1 with address sp+2 and data pc[15:8]. That second cycle also has `sp_we` with value sp+2 and `pc_we` with the vector. Here sp and pc are the values seen at acceptance.
- R7: `tf0_clr` or `tf1_clr` pulses in that second push cycle when timer 0 or timer 1 was taken. Serial and timer 2 produce no clear strobe.
- R8: `svc_lvl` is encoded as 0 idle, 1 low, 2 high. A class is examined only if `svc_lvl` is strictly below it. A low request can therefore be taken only from idle, and a high request only from idle or low. Acceptance sets `svc_lvl` to the taken class, visible in the first push cycle.
- R9: A `reti` pulse sets `svc_lvl` to the class that was in service before the current one: low when high was nested over low, otherwise idle.
- R10: After reset `svc_lvl` is idle and no stack, stack-pointer or program-counter write is issued.
- R11: Requests are examined only on cycles with `cycle_en` at 1. Nothing is accepted while a push is in progress or while `reti` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_en | input | 1 | Machine-cycle strobe; arbitration happens only here |
| reti | input | 1 | Return-from-interrupt pulse |
| ie_reg | input | 8 | Interrupt-enable register |
| ip_reg | input | 8 | Interrupt-priority register |
| tcon_reg | input | 8 | Timer control flags |
| scon_reg | input | 8 | Serial control flags |
| t2con_reg | input | 8 | Timer-2 control flags |
| pc_cur | input | 16 | Current program counter |
| sp_cur | input | SP_W | Current stack pointer |
| stk_we | output | 1 | Stack byte write enable |
| stk_addr | output | SP_W | Stack byte write address |
| stk_data | output | 8 | Stack byte write data |
| sp_we | output | 1 | Stack pointer write-back enable |
| sp_wdata | output | SP_W | New stack pointer |
| pc_we | output | 1 | Program counter load enable |
| pc_wdata | output | 16 | Vector address to load |
| tf0_clr | output | 1 | Clear timer 0 request flag |
| tf1_clr | output | 1 | Clear timer 1 request flag |
| svc_lvl | output | 2 | Class in service (0 idle, 1 low, 2 high) |

## Verification
The selection logic is tried with several input patterns:
- Single sources, which prove each request bit, vector and clear strobe.
- All four sources pending in the low class, which exposes the polling order.
- A late-polled source raised to the high class, which shows that class beats order.
- Patterns with the global or a local enable missing, which must produce no push at all.

Directed sequences cover three more cases. A high request nesting over a low one tells correct class gating apart from plain single-level masking. A second request in the class already in service must be refused. Two `reti` pulses must unwind high to low and then low to idle, after which a previously blocked low request is taken.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int BYTE_W = 8;
    localparam int PC_W   = 2 * BYTE_W;
    localparam int NSRC   = 4;
    localparam int GE_BIT = 7;

    typedef enum logic [1:0] {LVL_IDLE = 2'd0, LVL_LO = 2'd1, LVL_HI = 2'd2} lvl_e;
    typedef enum logic [1:0] {SRC_T0 = 2'd0, SRC_T1 = 2'd1, SRC_SER = 2'd2, SRC_T2 = 2'd3} src_e;
    typedef enum logic [1:0] {SEQ_IDLE, SEQ_LO, SEQ_HI} seq_e;

    typedef struct packed {
        logic valid;
        src_e src;
        lvl_e lvl;
    } grant_t;

    // enable / priority bit position of each source, in polling order
    function automatic int src_bit(input int idx);
        case (idx)
            0:       return 1;
            1:       return 3;
            2:       return 4;
            default: return 5;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] src_vector(input src_e s);
        case (s)
            SRC_T0:  return 8'h0B;
            SRC_T1:  return 8'h1B;
            SRC_SER: return 8'h23;
            default: return 8'h2B;
        endcase
    endfunction
endpackage

// File: rtl/irq_select.sv
module irq_select
    import irq_pkg::*;
(
    input  logic [BYTE_W-1:0] ie_reg,
    input  logic [BYTE_W-1:0] ip_reg,
    input  logic [BYTE_W-1:0] tcon_reg,
    input  logic [BYTE_W-1:0] scon_reg,
    input  logic [BYTE_W-1:0] t2con_reg,
    input  lvl_e              cur_lvl,
    output grant_t            grant
);
    logic [NSRC-1:0] req, hi_pend, lo_pend;

    assign req[0] = tcon_reg[5];
    assign req[1] = tcon_reg[7];
    assign req[2] = scon_reg[0] | scon_reg[1];
    assign req[3] = t2con_reg[7];

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam int B = src_bit(i);
        assign hi_pend[i] = ie_reg[B] &  ip_reg[B] & req[i];
        assign lo_pend[i] = ie_reg[B] & ~ip_reg[B] & req[i];
    end

    always_comb begin
        grant.valid = 1'b0;
        grant.src   = SRC_T0;
        grant.lvl   = LVL_IDLE;
        if (ie_reg[GE_BIT]) begin
            // low class only from idle
            if (cur_lvl == LVL_IDLE) begin
                for (int i = NSRC - 1; i >= 0; i--) begin
                    if (lo_pend[i]) begin
                        grant.valid = 1'b1;
                        grant.src   = src_e'(i);
                        grant.lvl   = LVL_LO;
                    end
                end
            end
            // high class overrides, examined while below high
            if (cur_lvl != LVL_HI && (|hi_pend)) begin
                for (int i = NSRC - 1; i >= 0; i--) begin
                    if (hi_pend[i]) begin
                        grant.valid = 1'b1;
                        grant.src   = src_e'(i);
                        grant.lvl   = LVL_HI;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/irq_level.sv
module irq_level
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  lvl_e new_lvl,
    input  logic reti,
    output lvl_e cur_lvl
);
    lvl_e prev_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_lvl  <= LVL_IDLE;
            prev_lvl <= LVL_IDLE;
        end else if (reti) begin
            cur_lvl  <= prev_lvl;
            prev_lvl <= LVL_IDLE;
        end else if (accept) begin
            prev_lvl <= cur_lvl;
            cur_lvl  <= new_lvl;
        end
    end

    // R8: an accepted class is strictly above the one in service
    p_gate_up_r8: assert property (@(posedge clk) disable iff (rst)
        accept |-> (logic'(new_lvl) > logic'(cur_lvl)) || (new_lvl == LVL_HI && cur_lvl != LVL_HI))
        else $error("class gating violated");

    // R9: a return lowers the class in service
    p_reti_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (reti && cur_lvl != LVL_IDLE) |=> (2'(cur_lvl) < $past(2'(cur_lvl))))
        else $error("reti did not lower class");
endmodule

// File: rtl/irq_push_seq.sv
module irq_push_seq
    import irq_pkg::*;
#(
    parameter int SP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  src_e              src,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [SP_W-1:0]   sp_in,
    output logic              busy,
    output logic              stk_we,
    output logic [SP_W-1:0]   stk_addr,
    output logic [BYTE_W-1:0] stk_data,
    output logic              sp_we,
    output logic [SP_W-1:0]   sp_wdata,
    output logic              pc_we,
    output logic [PC_W-1:0]   pc_wdata,
    output logic              tf0_clr,
    output logic              tf1_clr
);
    seq_e            st;
    logic [PC_W-1:0] pc_q;
    logic [SP_W-1:0] sp_q;
    src_e            src_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SEQ_IDLE;
            pc_q  <= '0;
            sp_q  <= '0;
            src_q <= SRC_T0;
        end else begin
            case (st)
                SEQ_IDLE: if (accept) begin
                    st    <= SEQ_LO;
                    pc_q  <= pc_in;
                    sp_q  <= sp_in;
                    src_q <= src;
                end
                SEQ_LO:  st <= SEQ_HI;
                default: st <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (st != SEQ_IDLE);
        stk_we   = (st == SEQ_LO) || (st == SEQ_HI);
        stk_addr = sp_q + ((st == SEQ_HI) ? SP_W'(2) : SP_W'(1));
        stk_data = (st == SEQ_HI) ? pc_q[PC_W-1:BYTE_W] : pc_q[BYTE_W-1:0];
        sp_we    = (st == SEQ_HI);
        sp_wdata = sp_q + SP_W'(2);
        pc_we    = (st == SEQ_HI);
        pc_wdata = PC_W'(src_vector(src_q));
        tf0_clr  = (st == SEQ_HI) && (src_q == SRC_T0);
        tf1_clr  = (st == SEQ_HI) && (src_q == SRC_T1);
    end

    // R6: low byte write is followed by the high byte one slot above, with write-back
    p_push_order_r6: assert property (@(posedge clk) disable iff (rst)
        (stk_we && !sp_we) |=> (stk_we && sp_we && pc_we && stk_addr == $past(stk_addr) + SP_W'(1)))
        else $error("push order broken");

    // R7: a flag clear only accompanies the vector load, never both timers
    p_clr_final_r7: assert property (@(posedge clk) disable iff (rst)
        (tf0_clr || tf1_clr) |-> (pc_we && !(tf0_clr && tf1_clr)))
        else $error("flag clear out of place");
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int SP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cycle_en,
    input  logic              reti,
    input  logic [7:0]        ie_reg,
    input  logic [7:0]        ip_reg,
    input  logic [7:0]        tcon_reg,
    input  logic [7:0]        scon_reg,
    input  logic [7:0]        t2con_reg,
    input  logic [15:0]       pc_cur,
    input  logic [SP_W-1:0]   sp_cur,
    output logic              stk_we,
    output logic [SP_W-1:0]   stk_addr,
    output logic [7:0]        stk_data,
    output logic              sp_we,
    output logic [SP_W-1:0]   sp_wdata,
    output logic              pc_we,
    output logic [15:0]       pc_wdata,
    output logic              tf0_clr,
    output logic              tf1_clr,
    output logic [1:0]        svc_lvl
);
    grant_t grant;
    lvl_e   cur_lvl;
    logic   busy, accept;

    irq_select u_sel (
        .ie_reg(ie_reg), .ip_reg(ip_reg), .tcon_reg(tcon_reg),
        .scon_reg(scon_reg), .t2con_reg(t2con_reg),
        .cur_lvl(cur_lvl), .grant(grant)
    );

    assign accept = cycle_en && !busy && !reti && grant.valid;

    irq_level u_lvl (
        .clk(clk), .rst(rst), .accept(accept),
        .new_lvl(grant.lvl), .reti(reti), .cur_lvl(cur_lvl)
    );

    irq_push_seq #(.SP_W(SP_W)) u_seq (
        .clk(clk), .rst(rst), .accept(accept), .src(grant.src),
        .pc_in(pc_cur), .sp_in(sp_cur), .busy(busy),
        .stk_we(stk_we), .stk_addr(stk_addr), .stk_data(stk_data),
        .sp_we(sp_we), .sp_wdata(sp_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata),
        .tf0_clr(tf0_clr), .tf1_clr(tf1_clr)
    );

    assign svc_lvl = cur_lvl;

    // R11: without a machine-cycle strobe and with no push running, no write starts
    p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (!cycle_en && !busy) |=> !stk_we)
        else $error("push started without cycle strobe");

    // R1: every push start was preceded by the global enable
    p_global_en_r1: assert property (@(posedge clk) disable iff (rst)
        (stk_we && !sp_we) |-> $past(ie_reg[GE_BIT]))
        else $error("accepted with global enable low");

    // R10: in-service encoding stays legal
    p_lvl_legal_r10: assert property (@(posedge clk) disable iff (rst)
        svc_lvl != 2'b11)
        else $error("illegal class code");
endmodule

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;
    logic        clk = 1'b0, rst = 1'b1, cycle_en = 1'b0, reti = 1'b0;
    logic [7:0]  ie_reg = '0, ip_reg = '0, tcon_reg = '0, scon_reg = '0, t2con_reg = '0;
    logic [15:0] pc_cur = 16'h1234;
    logic [7:0]  sp_cur = 8'h30;
    logic        stk_we, sp_we, pc_we, tf0_clr, tf1_clr;
    logic [7:0]  stk_addr, stk_data, sp_wdata;
    logic [15:0] pc_wdata;
    logic [1:0]  svc_lvl;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_arbiter u_irq_arbiter (
        .clk(clk), .rst(rst), .cycle_en(cycle_en), .reti(reti),
        .ie_reg(ie_reg), .ip_reg(ip_reg), .tcon_reg(tcon_reg),
        .scon_reg(scon_reg), .t2con_reg(t2con_reg),
        .pc_cur(pc_cur), .sp_cur(sp_cur),
        .stk_we(stk_we), .stk_addr(stk_addr), .stk_data(stk_data),
        .sp_we(sp_we), .sp_wdata(sp_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata),
        .tf0_clr(tf0_clr), .tf1_clr(tf1_clr), .svc_lvl(svc_lvl)
    );

    typedef struct packed {
        logic [7:0] ie, ip, tcon, scon, t2con;
        logic       take;
        logic [7:0] vec;
        logic [1:0] lvl;
        logic       c0, c1;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{8'h82, 8'h00, 8'h20, 8'h00, 8'h00, 1'b1, 8'h0B, 2'd1, 1'b1, 1'b0}, // R5 R7 timer0
        '{8'h88, 8'h00, 8'h80, 8'h00, 8'h00, 1'b1, 8'h1B, 2'd1, 1'b0, 1'b1}, // R5 R7 timer1
        '{8'h90, 8'h00, 8'h00, 8'h01, 8'h00, 1'b1, 8'h23, 2'd1, 1'b0, 1'b0}, // R5 serial bit0
        '{8'h90, 8'h00, 8'h00, 8'h02, 8'h00, 1'b1, 8'h23, 2'd1, 1'b0, 1'b0}, // R5 serial bit1
        '{8'hA0, 8'h00, 8'h00, 8'h00, 8'h80, 1'b1, 8'h2B, 2'd1, 1'b0, 1'b0}, // R5 timer2
        '{8'h02, 8'h00, 8'h20, 8'h00, 8'h00, 1'b0, 8'h00, 2'd0, 1'b0, 1'b0}, // R1 no global
        '{8'h88, 8'h00, 8'h20, 8'h00, 8'h00, 1'b0, 8'h00, 2'd0, 1'b0, 1'b0}, // R2 own enable off
        '{8'hBA, 8'h00, 8'hA0, 8'h01, 8'h80, 1'b1, 8'h0B, 2'd1, 1'b1, 1'b0}, // R4 all low
        '{8'hBA, 8'h00, 8'h80, 8'h01, 8'h80, 1'b1, 8'h1B, 2'd1, 1'b0, 1'b1}, // R4 t1 first
        '{8'hBA, 8'h20, 8'hA0, 8'h01, 8'h80, 1'b1, 8'h2B, 2'd2, 1'b0, 1'b0}, // R3 t2 high
        '{8'hBA, 8'h10, 8'h20, 8'h03, 8'h00, 1'b1, 8'h23, 2'd2, 1'b0, 1'b0}, // R3 serial high
        '{8'hB0, 8'h00, 8'h00, 8'h01, 8'h80, 1'b1, 8'h23, 2'd1, 1'b0, 1'b0}  // R4 serial before t2
    };
    string tags [NV] = '{"R5","R5","R5","R5","R5","R1","R2","R4","R4","R3","R3","R4"};

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        cycle_en = 0; reti = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // strobe one machine cycle, then check both push slots (R6)
    task automatic strobe_and_check(input string tag, input logic take, input logic [7:0] vec,
                                    input logic [1:0] lvl, input logic c0, input logic c1);
        @(negedge clk) cycle_en = 1'b1;
        @(negedge clk) cycle_en = 1'b0;
        chk({tag, " R6 lo we"}, stk_we, take);
        chk({tag, " R8 lvl"}, svc_lvl, lvl);
        if (take) begin
            chk({tag, " R6 lo addr"}, stk_addr, sp_cur + 8'd1);
            chk({tag, " R6 lo data"}, stk_data, pc_cur[7:0]);
        end
        @(negedge clk);
        chk({tag, " R6 hi we"}, stk_we, take);
        chk({tag, " R6 pc_we"}, pc_we, take);
        if (take) begin
            chk({tag, " R6 hi addr"}, stk_addr, sp_cur + 8'd2);
            chk({tag, " R6 hi data"}, stk_data, pc_cur[15:8]);
            chk({tag, " R6 sp wb"}, sp_wdata, sp_cur + 8'd2);
            chk({tag, " R5 vector"}, pc_wdata, {8'h00, vec});
        end
        chk({tag, " R7 clr0"}, tf0_clr, c0);
        chk({tag, " R7 clr1"}, tf1_clr, c1);
        @(negedge clk);
    endtask

    task automatic pulse_reti();
        @(negedge clk) reti = 1'b1;
        @(negedge clk) reti = 1'b0;
    endtask

    initial begin
        // R10 reset state
        do_reset();
        chk("R10 lvl", svc_lvl, 0);
        chk("R10 stk_we", stk_we, 0);
        chk("R10 sp_we", sp_we, 0);
        chk("R10 pc_we", pc_we, 0);

        // table walk
        for (int k = 0; k < NV; k++) begin
            do_reset();
            ie_reg = TBL[k].ie; ip_reg = TBL[k].ip; tcon_reg = TBL[k].tcon;
            scon_reg = TBL[k].scon; t2con_reg = TBL[k].t2con;
            strobe_and_check(tags[k], TBL[k].take, TBL[k].vec, TBL[k].lvl, TBL[k].c0, TBL[k].c1);
        end

        // R11: pending request with no machine-cycle strobe is not taken
        do_reset();
        ie_reg = 8'h82; ip_reg = 8'h00; tcon_reg = 8'h20; scon_reg = 0; t2con_reg = 0;
        repeat (3) @(negedge clk);
        chk("R11 no strobe we", stk_we, 0);
        chk("R11 no strobe lvl", svc_lvl, 0);

        // R8 nesting low then high, blocking at same level
        do_reset();
        pc_cur = 16'h4567; sp_cur = 8'h30;
        ie_reg = 8'hAA; ip_reg = 8'h20; tcon_reg = 8'h20; t2con_reg = 8'h00;
        strobe_and_check("R8 low first", 1'b1, 8'h0B, 2'd1, 1'b1, 1'b0);
        tcon_reg = 8'h80; sp_cur = 8'h32;           // timer1 low pending, same class
        strobe_and_check("R8 same low blocked", 1'b0, 8'h00, 2'd1, 1'b0, 1'b0);
        t2con_reg = 8'h80; pc_cur = 16'h89AB;       // timer2 high nests over low
        strobe_and_check("R8 nest high", 1'b1, 8'h2B, 2'd2, 1'b0, 1'b0);
        sp_cur = 8'h34; ip_reg = 8'hA8;             // timer1 now high too
        strobe_and_check("R8 same high blocked", 1'b0, 8'h00, 2'd2, 1'b0, 1'b0);

        // R9 unwinding
        t2con_reg = 8'h00; ip_reg = 8'h20; tcon_reg = 8'h00;
        pulse_reti();
        chk("R9 high back to low", svc_lvl, 1);
        pulse_reti();
        chk("R9 low back to idle", svc_lvl, 0);
        tcon_reg = 8'h80;                           // blocked timer1 low now taken
        strobe_and_check("R9 after unwind", 1'b1, 8'h1B, 2'd1, 1'b0, 1'b1);
        tcon_reg = 8'h00;
        pulse_reti();
        chk("R9 single to idle", svc_lvl, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog (R1..): run did not complete, got hang expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule